// File: doc/BRIEF.md
# Soft-Start and Output-Charge Sequencer

This block sequences the start of a current-mode power converter. It waits for a start request and then for the input-voltage and die-temperature checks to report good. It then raises the cycle-by-cycle peak-current limit through three equal timed steps up to a configured startup limit. After the last step it holds that limit and requests maximum on-time, so that the output charges until the sensed output-voltage code reaches the self-supply level. At that point it enables the regulation loop and switches to the normal regulation limit.

A timeout runs from the first ramp step. If the output has not reached the self-supply level when the timeout expires, the block raises a startup undervoltage fault and parks until it is aborted. An outside restart supervisor reacts to that fault. The block also arms the regulated-mode output undervoltage protection, but only once the loop has taken over. A synchronous abort returns the sequencer to idle from any state. Step duration and timeout are counted in ticks of an external timebase strobe.

Top module: `softstart_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it, all outputs are zero: `ilim_o` = 0, and `max_on_o`, `loop_en_o`, `uv_fault_o` and `uvp_arm_o` are low.
- R2: A `start_i` pulse in idle moves the block into a wait state. The ramp begins one cycle after both `vin_ok_i` and `tj_ok_i` are sampled high. While it waits, all outputs stay zero.
- R3: During ramp step k (k = 1, 2, 3), `ilim_o` equals floor(k * `ilim_start_i` / 3). Step 3 therefore equals `ilim_start_i`.
- R4: Each ramp step lasts `step_ticks_i` ticks, and a value of 0 counts as 1. The block advances in the cycle after the tick that completes the step.
- R5: During charging, `max_on_o` is high, `ilim_o` equals `ilim_start_i`, and `loop_en_o` is low.
- R6: While charging, sampling `vout_code_i >= vout_start_i` moves the block to regulation one cycle later. In regulation `loop_en_o` is high, `max_on_o` is low and `ilim_o` equals `ilim_run_i`.
- R7: The block counts the ticks seen in ramp and charge since entering step 1. When that count reaches `timeout_ticks_i` (0 counts as 1) the block enters the fault state. There `uv_fault_o` is high and `ilim_o` is 0, and this holds until abort. In charging, reaching the self-supply level in the same cycle wins over the timeout.
- R8: `uvp_arm_o` is high only in regulation. It is low throughout ramp and charge.
- R9: Sampling `abort_i` high returns the block to idle from any state. All outputs are zero in the next cycle, and the block stays idle until the next `start_i`.
- R10: `uv_fault_o` and `loop_en_o` are never high together, and neither are `max_on_o` and `loop_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| abort_i | input | 1 | Synchronous return to idle |
| start_i | input | 1 | Start request, taken in idle |
| vin_ok_i | input | 1 | Input voltage within limits |
| tj_ok_i | input | 1 | Junction temperature within limits |
| tick_i | input | 1 | Timebase strobe, one cycle wide |
| vout_code_i | input | VOUT_W | Sensed output-voltage code |
| vout_start_i | input | VOUT_W | Self-supply output level |
| ilim_start_i | input | LIM_W | Startup peak-current limit code |
| ilim_run_i | input | LIM_W | Regulation peak-current limit code |
| step_ticks_i | input | STEP_W | Ticks per ramp step |
| timeout_ticks_i | input | TO_W | Startup timeout in ticks |
| ilim_o | output | LIM_W | Peak-current limit code |
| max_on_o | output | 1 | Maximum on-time request |
| loop_en_o | output | 1 | Regulation loop enable |
| uv_fault_o | output | 1 | Startup output undervoltage fault |
| uvp_arm_o | output | 1 | Regulated output undervoltage protection armed |

## Verification
The assertions assume that the limit codes and thresholds stay constant whenever the sequencer is out of idle. Only under that assumption are the ramp codes non-decreasing and the charge limit equal to the startup input. The stimulus changes configuration only after an abort or reset has put the block in idle. `tick_i` is produced by one generator that either stays off, toggles every other cycle, or pulses every cycle, and `abort_i` and `start_i` are only ever single-cycle pulses.

// File: rtl/softstart_pkg.sv
package softstart_pkg;
  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_WAIT   = 3'd1,
    S_RAMP   = 3'd2,
    S_CHARGE = 3'd3,
    S_RUN    = 3'd4,
    S_FAULT  = 3'd5
  } ss_state_t;
endpackage

// File: rtl/ss_tick_cnt.sv
// Counts timebase ticks since the last clear; done_o flags the tick that
// brings the count to the limit (a limit of zero behaves as one).
module ss_tick_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;
  logic [W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
  assign done_o  = tick_i && (cnt_inc >= {1'b0, limit_i});

  always_ff @(posedge clk) begin
    if (rst || clear_i)
      cnt_q <= '0;
    else if (tick_i && !done_o)
      cnt_q <= cnt_inc[W-1:0];
  end
endmodule

// File: rtl/ss_limit_steps.sv
// Builds the ramp limit codes: entry k is floor((k+1) * start / N_STEPS).
module ss_limit_steps #(
  parameter int LIM_W   = 10,
  parameter int N_STEPS = 3
) (
  input  logic [LIM_W-1:0] ilim_start_i,
  output logic [LIM_W-1:0] codes_o [N_STEPS]
);
  localparam int MW = LIM_W + $clog2(N_STEPS + 1);

  for (genvar k = 0; k < N_STEPS; k++) begin : g_step
    logic [MW-1:0] prod;
    logic [MW-1:0] quot;
    assign prod       = MW'(ilim_start_i) * MW'(k + 1);
    assign quot       = prod / MW'(N_STEPS);
    assign codes_o[k] = quot[LIM_W-1:0];
  end
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
  import softstart_pkg::*;
#(
  parameter int LIM_W   = 10,
  parameter int VOUT_W  = 12,
  parameter int STEP_W  = 16,
  parameter int TO_W    = 20,
  parameter int N_STEPS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort_i,
  input  logic              start_i,
  input  logic              vin_ok_i,
  input  logic              tj_ok_i,
  input  logic              tick_i,
  input  logic [VOUT_W-1:0] vout_code_i,
  input  logic [VOUT_W-1:0] vout_start_i,
  input  logic [LIM_W-1:0]  ilim_start_i,
  input  logic [LIM_W-1:0]  ilim_run_i,
  input  logic [STEP_W-1:0] step_ticks_i,
  input  logic [TO_W-1:0]   timeout_ticks_i,
  output logic [LIM_W-1:0]  ilim_o,
  output logic              max_on_o,
  output logic              loop_en_o,
  output logic              uv_fault_o,
  output logic              uvp_arm_o
);
  localparam int IDX_W = (N_STEPS > 1) ? $clog2(N_STEPS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_STEPS - 1);

  ss_state_t        state_q, state_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [LIM_W-1:0] step_codes [N_STEPS];
  logic [LIM_W-1:0] ilim_n;
  logic             step_done, to_done;
  logic             step_clear, to_clear;
  logic             vout_reached;

  assign vout_reached = (vout_code_i >= vout_start_i);
  assign step_clear   = (state_q != S_RAMP) || step_done;
  assign to_clear     = (state_q != S_RAMP) && (state_q != S_CHARGE);

  ss_limit_steps #(.LIM_W(LIM_W), .N_STEPS(N_STEPS)) u_codes (
    .ilim_start_i (ilim_start_i),
    .codes_o      (step_codes)
  );

  ss_tick_cnt #(.W(STEP_W)) u_step_cnt (
    .clk     (clk),
    .rst     (rst),
    .clear_i (step_clear),
    .tick_i  (tick_i),
    .limit_i (step_ticks_i),
    .done_o  (step_done)
  );

  ss_tick_cnt #(.W(TO_W)) u_to_cnt (
    .clk     (clk),
    .rst     (rst),
    .clear_i (to_clear),
    .tick_i  (tick_i),
    .limit_i (timeout_ticks_i),
    .done_o  (to_done)
  );

  always_comb begin
    state_n = state_q;
    idx_n   = idx_q;
    if (abort_i) begin
      state_n = S_IDLE;
      idx_n   = '0;
    end else begin
      unique case (state_q)
        S_IDLE:   if (start_i) state_n = S_WAIT;
        S_WAIT:   if (vin_ok_i && tj_ok_i) begin
                    state_n = S_RAMP;
                    idx_n   = '0;
                  end
        S_RAMP:   if (to_done) state_n = S_FAULT;
                  else if (step_done) begin
                    if (idx_q == LAST_IDX) state_n = S_CHARGE;
                    else                   idx_n   = idx_q + 1'b1;
                  end
        S_CHARGE: if (vout_reached) state_n = S_RUN;
                  else if (to_done) state_n = S_FAULT;
        S_RUN:    state_n = S_RUN;
        S_FAULT:  state_n = S_FAULT;
        default:  state_n = S_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_n)
      S_RAMP:   ilim_n = step_codes[idx_n];
      S_CHARGE: ilim_n = ilim_start_i;
      S_RUN:    ilim_n = ilim_run_i;
      default:  ilim_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      idx_q      <= '0;
      ilim_o     <= '0;
      max_on_o   <= 1'b0;
      loop_en_o  <= 1'b0;
      uv_fault_o <= 1'b0;
      uvp_arm_o  <= 1'b0;
    end else begin
      state_q    <= state_n;
      idx_q      <= idx_n;
      ilim_o     <= ilim_n;
      max_on_o   <= (state_n == S_CHARGE);
      loop_en_o  <= (state_n == S_RUN);
      uv_fault_o <= (state_n == S_FAULT);
      uvp_arm_o  <= (state_n == S_RUN);
    end
  end
endmodule

// File: rtl/softstart_seq_chk.sv
module softstart_seq_chk #(
  parameter int LIM_W  = 10,
  parameter int VOUT_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              abort_i,
  input logic [VOUT_W-1:0] vout_code_i,
  input logic [VOUT_W-1:0] vout_start_i,
  input logic [LIM_W-1:0]  ilim_start_i,
  input logic [LIM_W-1:0]  ilim_o,
  input logic              max_on_o,
  input logic              loop_en_o,
  input logic              uv_fault_o,
  input logic              uvp_arm_o
);
  a_r10_fault_loop_excl: assert property (@(posedge clk) disable iff (rst)
    !(uv_fault_o && loop_en_o));

  a_r10_maxon_loop_excl: assert property (@(posedge clk) disable iff (rst)
    !(max_on_o && loop_en_o));

  a_r9_abort_clears: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> (ilim_o == '0) && !max_on_o && !loop_en_o && !uv_fault_o && !uvp_arm_o);

  a_r6_run_needs_vout: assert property (@(posedge clk) disable iff (rst)
    $rose(loop_en_o) |-> $past(vout_code_i >= vout_start_i) && $past(max_on_o));

  a_r7_fault_sticky: assert property (@(posedge clk) disable iff (rst)
    (uv_fault_o && !abort_i) |=> uv_fault_o);

  a_r5_charge_limit: assert property (@(posedge clk) disable iff (rst)
    max_on_o |-> (ilim_o == ilim_start_i));

  a_r3_ramp_monotonic: assert property (@(posedge clk) disable iff (rst)
    (ilim_o != '0 && !loop_en_o && $past(ilim_o != '0 && !loop_en_o))
      |-> (ilim_o >= $past(ilim_o)));

  a_r8_uvp_only_run: assert property (@(posedge clk) disable iff (rst)
    $rose(uvp_arm_o) |-> $past(max_on_o));
endmodule

bind softstart_seq softstart_seq_chk #(.LIM_W(LIM_W), .VOUT_W(VOUT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .abort_i      (abort_i),
  .vout_code_i  (vout_code_i),
  .vout_start_i (vout_start_i),
  .ilim_start_i (ilim_start_i),
  .ilim_o       (ilim_o),
  .max_on_o     (max_on_o),
  .loop_en_o    (loop_en_o),
  .uv_fault_o   (uv_fault_o),
  .uvp_arm_o    (uvp_arm_o)
);

// File: tb/tb_softstart_seq.sv
module tb_softstart_seq;
  localparam int LIM_W = 10, VOUT_W = 12, STEP_W = 16, TO_W = 20;

  logic clk = 1'b0, rst = 1'b1;
  logic abort_i = 0, start_i = 0, vin_ok_i = 0, tj_ok_i = 0, tick_i = 0;
  logic [VOUT_W-1:0] vout_code_i = '0, vout_start_i = '0;
  logic [LIM_W-1:0]  ilim_start_i = '0, ilim_run_i = '0;
  logic [STEP_W-1:0] step_ticks_i = '0;
  logic [TO_W-1:0]   timeout_ticks_i = '0;
  logic [LIM_W-1:0]  ilim_o;
  logic max_on_o, loop_en_o, uv_fault_o, uvp_arm_o;

  softstart_seq dut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  int tick_mode = 0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // tick generator: 0 off, 1 every other cycle, 2 every cycle
  always @(negedge clk) begin
    #1;
    if (tick_mode == 2)      tick_i = 1'b1;
    else if (tick_mode == 1) tick_i = !tick_i;
    else                     tick_i = 1'b0;
  end

  // behavioural reference: phase 0 idle, 1 wait, 2..4 steps, 10 charge, 11 run, 12 fault
  int m_phase = 0, m_step_ticks = 0, m_to_ticks = 0;
  bit started = 0;
  always @(posedge clk) begin
    int st_lim, to_lim;
    st_lim = (step_ticks_i == 0) ? 1 : int'(step_ticks_i);
    to_lim = (timeout_ticks_i == 0) ? 1 : int'(timeout_ticks_i);
    started = 1;
    if (rst) m_phase = 0;
    else if (abort_i) m_phase = 0;
    else if (m_phase == 0) begin
      if (start_i) m_phase = 1;
    end else if (m_phase == 1) begin
      if (vin_ok_i && tj_ok_i) begin
        m_phase = 2; m_step_ticks = 0; m_to_ticks = 0;
      end
    end else if (m_phase >= 2 && m_phase <= 4) begin
      if (tick_i) begin m_step_ticks++; m_to_ticks++; end
      if (m_to_ticks >= to_lim) m_phase = 12;
      else if (m_step_ticks >= st_lim) begin
        m_step_ticks = 0;
        m_phase = (m_phase == 4) ? 10 : m_phase + 1;
      end
    end else if (m_phase == 10) begin
      if (tick_i) m_to_ticks++;
      if (vout_code_i >= vout_start_i) m_phase = 11;
      else if (m_to_ticks >= to_lim) m_phase = 12;
    end
  end

  function automatic int exp_ilim();
    if (m_phase >= 2 && m_phase <= 4) return (int'(ilim_start_i) * (m_phase - 1)) / 3;
    if (m_phase == 10) return int'(ilim_start_i);
    if (m_phase == 11) return int'(ilim_run_i);
    return 0;
  endfunction

  always @(negedge clk) begin
    if (started) begin
      chk(int'(ilim_o) == exp_ilim(), cur_req, int'(ilim_o), exp_ilim());
      chk(max_on_o == (m_phase == 10), cur_req, max_on_o, m_phase == 10);
      chk(loop_en_o == (m_phase == 11), cur_req, loop_en_o, m_phase == 11);
      chk(uv_fault_o == (m_phase == 12), cur_req, uv_fault_o, m_phase == 12);
      chk(uvp_arm_o == (m_phase == 11), "R8", uvp_arm_o, m_phase == 11);
      chk(!(uv_fault_o && loop_en_o) && !(max_on_o && loop_en_o), "R10", 1, 0);
    end
  end

  // ticks seen while the outputs show the ramp
  int ramp_ticks = 0;
  always @(posedge clk)
    if (tick_i && ilim_o != 0 && !max_on_o && !loop_en_o && !uv_fault_o) ramp_ticks++;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic pulse_start();
    start_i = 1'b1; cyc(1); start_i = 1'b0;
  endtask

  task automatic pulse_abort();
    abort_i = 1'b1; cyc(1); abort_i = 1'b0;
  endtask

  initial begin
    cyc(3);
    chk(ilim_o == 0 && !max_on_o && !loop_en_o && !uv_fault_o, "R1", ilim_o, 0);
    rst = 1'b0;
    ilim_start_i = 90; ilim_run_i = 200; vout_start_i = 500;
    step_ticks_i = 3; timeout_ticks_i = 1000; tick_mode = 1;
    @(negedge clk);
    chk(ilim_o == 0 && !uvp_arm_o, "R1", ilim_o, 0);
    #2;

    cur_req = "R2"; vin_ok_i = 1; tj_ok_i = 0;
    pulse_start(); cyc(20);
    chk(ilim_o == 0 && !max_on_o, "R2", ilim_o, 0);
    tj_ok_i = 1; ramp_ticks = 0;
    cur_req = "R3";
    while (ilim_o == 0) @(negedge clk);
    chk(ilim_o == 30, "R3", ilim_o, 30);
    while (ilim_o == 30) @(negedge clk);
    chk(ilim_o == 60, "R3", ilim_o, 60);
    cur_req = "R5";
    while (!max_on_o) @(negedge clk);
    chk(ilim_o == 90 && !loop_en_o, "R5", ilim_o, 90);
    chk(ramp_ticks == 9, "R4", ramp_ticks, 9);
    #2; vout_code_i = 499; cyc(10);
    chk(max_on_o == 1, "R6", max_on_o, 1);
    cur_req = "R6"; vout_code_i = 500; cyc(1);
    @(negedge clk);
    chk(loop_en_o && ilim_o == 200 && !max_on_o, "R6", ilim_o, 200);
    chk(uvp_arm_o == 1, "R8", uvp_arm_o, 1);
    #2; cur_req = "R9"; pulse_abort();
    @(negedge clk);
    chk(ilim_o == 0 && !loop_en_o && !uvp_arm_o, "R9", ilim_o, 0);
    #2;

    cur_req = "R7"; vout_code_i = 0; timeout_ticks_i = 12;
    pulse_start();
    while (!uv_fault_o) @(negedge clk);
    chk(ilim_o == 0, "R7", ilim_o, 0);
    #2; cyc(20);
    chk(uv_fault_o == 1, "R7", uv_fault_o, 1);
    pulse_abort(); cyc(2);

    step_ticks_i = 5; timeout_ticks_i = 2;
    pulse_start();
    while (!uv_fault_o) @(negedge clk);
    chk(ilim_o == 0 && !max_on_o, "R7", ilim_o, 0);
    #2; pulse_abort(); cyc(2);

    cur_req = "R4"; step_ticks_i = 0; timeout_ticks_i = 1000; ramp_ticks = 0;
    pulse_start();
    while (!max_on_o) @(negedge clk);
    chk(ramp_ticks == 3, "R4", ramp_ticks, 3);
    #2; pulse_abort(); cyc(2);

    cur_req = "R7"; tick_mode = 2; step_ticks_i = 1; timeout_ticks_i = 4; vout_code_i = 600;
    cyc(1); pulse_start();
    while (!loop_en_o && !uv_fault_o) @(negedge clk);
    chk(loop_en_o && !uv_fault_o, "R7", uv_fault_o, 0);
    #2; pulse_abort(); cyc(2);

    cur_req = "R3"; tick_mode = 1; ilim_start_i = 100; step_ticks_i = 2; timeout_ticks_i = 1000;
    vout_code_i = 0;
    pulse_start();
    while (ilim_o == 0) @(negedge clk);
    chk(ilim_o == 33, "R3", ilim_o, 33);
    #2; cur_req = "R9"; pulse_abort();
    @(negedge clk);
    chk(ilim_o == 0 && !max_on_o, "R9", ilim_o, 0);
    #2; cyc(10);
    chk(ilim_o == 0 && !uv_fault_o, "R9", ilim_o, 0);
    cur_req = "R3"; pulse_start();
    while (ilim_o != 66) @(negedge clk);
    while (ilim_o == 66) @(negedge clk);
    chk(ilim_o == 100, "R3", ilim_o, 100);
    #2; pulse_abort(); cyc(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule